// File: doc/BRIEF.md
# Rotate-and-Mask Bit Field Unit

This datapath rotates a 32-bit word left by an immediate count and then ANDs it with a mask. The mask is not supplied as a constant. It is built on the fly from two 5-bit positions, a start and a stop, and both use numbering where position 0 is the most significant bit. One operation can pull a byte down to the low end of the word, keep a single flag bit, or keep a contiguous run of bits that straddles the half-word boundary. When the start position lies after the stop position, the mask wraps around the end of the word.

An optional output register, chosen by a parameter, adds one cycle of latency. It carries a valid bit beside the data. Without it the unit is purely combinational from its inputs to its result. Instruction decode, register files, flag updates and insert-under-mask are left to the surrounding logic.

Top module: `rotmask_unit`

## Requirements
- R1: The source word is rotated left by `rot_i` (0 to 31) before masking, so no bit is lost. With an all-ones mask, the result is exactly the rotated source.
- R2: Positions count from the most significant bit. Position p maps to LSB index 31-p, so start 24 with stop 31 keeps the low byte (mask 0x000000FF).
- R3: When start is not greater than stop, mask bits from start through stop inclusive are one and all others are zero. Start 28 with stop 28 gives 0x00000008, and start 8 with stop 23 gives 0x00FFFF00.
- R4: When start is greater than stop, the mask wraps. Positions from start up to 31 and from 0 up to stop are one, and the positions strictly between them are zero. Start 30 with stop 1 gives 0xC0000003.
- R5: When start equals stop plus one modulo 32 (including start 0 with stop 31), the mask is all ones and the unit acts as a pure rotate.
- R6: The result is the rotated word ANDed with the mask. Rotates of 8, 16 and 24 with start 24 and stop 31 return the first, second and third bytes, counted from the most significant byte, in the low byte.
- R7: With the output register enabled, `valid_o` and the matching result appear exactly one cycle after `valid_i` is sampled high, in order.
- R8: With the output register enabled, a cycle with `valid_i` low leaves `result_o` unchanged and drives `valid_o` low on the next cycle.
- R9: While `rst_ni` is low, `valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands are valid |
| src_i | input | 32 | Source word |
| rot_i | input | 5 | Left-rotate count |
| start_i | input | 5 | First mask position, MSB-first numbering |
| stop_i | input | 5 | Last mask position, MSB-first numbering |
| valid_o | output | 1 | Result is valid |
| result_o | output | 32 | Rotated and masked word |

## Verification
On every cycle, the assertions check the following:
- The rotator keeps the population count of the source word.
- The mask's population count equals the modular distance from start to stop plus one, which covers both the contiguous case and the wrapped case.
- A single position yields exactly one set bit.
- Start equal to stop plus one yields all ones.
- The valid pipeline follows `valid_i` one cycle late, and `result_o` holds steady while no new operand arrives.

The assertions do not pin down which bits the mask selects or in which direction the rotation goes. Only the bench's scenarios show these, through fixed expected words:
- byte extraction,
- the single-flag mask,
- the mask that crosses the half-word boundary,
- wrapped masks,
- rotations by 1 and 31.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned POS_W = $clog2(WORD_W);
endpackage

// File: rtl/rotmask_rotl.sv
module rotmask_rotl #(
  parameter int unsigned DATA_W = rotmask_pkg::WORD_W,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] data_o
);
  // log-depth barrel rotator, one stage per amount bit
  logic [DATA_W-1:0] stage [AMT_W+1];
  assign stage[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned SH = 2 ** k;
    assign stage[k+1] = amt_i[k] ?
      {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1:DATA_W-SH]} : stage[k];
  end

  assign data_o = stage[AMT_W];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int unsigned DATA_W = rotmask_pkg::WORD_W,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  start_i,
  input  logic [POS_W-1:0]  stop_i,
  output logic [DATA_W-1:0] mask_o
);
  logic wrap;
  assign wrap = start_i > stop_i;

  // position p (MSB-first) lives at LSB index DATA_W-1-p
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [POS_W-1:0] POS = POS_W'(DATA_W - 1 - i);
    logic ge_start, le_stop;
    assign ge_start  = POS >= start_i;
    assign le_stop   = POS <= stop_i;
    assign mask_o[i] = wrap ? (ge_start | le_stop) : (ge_start & le_stop);
  end
endmodule

// File: rtl/rotmask_outreg.sv
module rotmask_outreg #(
  parameter int unsigned DATA_W  = rotmask_pkg::WORD_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  if (REG_OUT) begin : g_reg
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) data_q <= data_i;
      end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    a_r8_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    a_r8_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(data_o));
    a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> data_o == $past(data_i));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int unsigned DATA_W  = rotmask_pkg::WORD_W,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned POS_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [POS_W-1:0]  rot_i,
  input  logic [POS_W-1:0]  start_i,
  input  logic [POS_W-1:0]  stop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] rotated, mask, masked;

  rotmask_rotl #(.DATA_W(DATA_W)) u_rotl (
    .data_i (src_i),
    .amt_i  (rot_i),
    .data_o (rotated)
  );

  rotmask_maskgen #(.DATA_W(DATA_W)) u_mask (
    .start_i (start_i),
    .stop_i  (stop_i),
    .mask_o  (mask)
  );

  assign masked = rotated & mask;

  rotmask_outreg #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (masked),
    .valid_o (valid_o),
    .data_o  (result_o)
  );

  // expected mask population: modular span from start to stop, plus one
  logic [POS_W:0] span_cnt;
  assign span_cnt = {1'b0, POS_W'(stop_i - start_i)} + 1'b1;

  a_r1_rot_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rotated) == $countones(src_i));
  a_r4_mask_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask) == span_cnt);
  a_r3_single_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i == stop_i) |-> $onehot0(mask) && mask != '0);
  a_r5_full_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i == POS_W'(stop_i + 1'b1)) |-> (&mask));
  a_r6_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked & ~rotated) == '0);
endmodule

// File: tb/rotmask_unit_test.sv
module rotmask_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] src_i = '0;
  logic [4:0]  rot_i = '0, start_i = '0, stop_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit seen_valid = 1'b0;
  logic [31:0] last_res = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rotmask_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .rot_i(rot_i), .start_i(start_i), .stop_i(stop_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [31:0] ref_mask(logic [4:0] s, logic [4:0] e);
    logic [31:0] m = '0;
    for (int p = 0; p < 32; p++) begin
      if (s <= e) m[31-p] = (p >= s) && (p <= e);
      else        m[31-p] = (p >= s) || (p <= e);
    end
    return m;
  endfunction

  function automatic logic [31:0] ref_rotl(logic [31:0] x, logic [4:0] r);
    logic [63:0] t = {x, x} << r;
    return t[63:32];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] s, logic [4:0] r, logic [4:0] b,
                       logic [4:0] e, logic [31:0] exp, string tag);
    @(negedge clk);
    valid_i = 1'b1; src_i = s; rot_i = r; start_i = b; stop_i = e;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(logic [31:0] junk);
    @(negedge clk);
    valid_i = 1'b0; src_i = junk; rot_i = junk[4:0];
    start_i = junk[9:5]; stop_i = junk[14:10];
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected valid_o", {31'b0, valid_o}, 32'h0);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, result_o, e);
          last_res = e;
          seen_valid = 1'b1;
        end
      end else if (seen_valid) begin
        check("R8 hold while idle", result_o, last_res);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    check("R9 reset valid_o", {31'b0, valid_o}, 32'h0);
    check("R9 reset result_o", result_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 after release valid_o", {31'b0, valid_o}, 32'h0);

    drive(32'hFFFF_FFFF, 5'd0, 5'd28, 5'd28, 32'h0000_0008, "R3 flag bit set");
    drive(32'h1234_5677, 5'd0, 5'd28, 5'd28, 32'h0000_0000, "R3 flag bit clear");
    drive(32'hA1B2_C3D4, 5'd0, 5'd24, 5'd31, 32'h0000_00D4, "R2 low byte");
    drive(32'hA1B2_C3D4, 5'd8, 5'd24, 5'd31, 32'h0000_00A1, "R6 byte0");
    drive(32'hA1B2_C3D4, 5'd16, 5'd24, 5'd31, 32'h0000_00B2, "R6 byte1");
    drive(32'hA1B2_C3D4, 5'd24, 5'd24, 5'd31, 32'h0000_00C3, "R6 byte2");
    drive(32'hA1B2_C3D4, 5'd0, 5'd8, 5'd23, 32'h00B2_C300, "R3 half-word crossing");
    idle(32'h5A5A_5A5A);
    idle(32'h0F0F_0F0F);
    drive(32'hFFFF_FFFF, 5'd0, 5'd30, 5'd1, 32'hC000_0003, "R4 wrap mask");
    drive(32'h8000_0001, 5'd1, 5'd31, 5'd0, 32'h0000_0001, "R4 wrap ends after rotate");
    drive(32'hA1B2_C3D4, 5'd4, 5'd5, 5'd4, 32'h1B2C_3D4A, "R5 start=stop+1");
    drive(32'hA1B2_C3D4, 5'd16, 5'd0, 5'd31, 32'hC3D4_A1B2, "R5 full range");
    drive(32'h0000_0001, 5'd31, 5'd0, 5'd31, 32'h8000_0000, "R1 rotate 31");
    drive(32'h8000_0000, 5'd1, 5'd0, 5'd31, 32'h0000_0001, "R1 rotate 1");
    idle(32'h1357_9BDF);

    for (int n = 0; n < 300; n++) begin
      automatic logic [31:0] s;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      s = lfsr ^ (lfsr << 7);
      drive(s, lfsr[4:0], lfsr[12:8], lfsr[20:16],
            ref_rotl(s, lfsr[4:0]) & ref_mask(lfsr[12:8], lfsr[20:16]),
            "R6 random operand");
      if (lfsr[27:25] == 3'd0) idle(~s);
    end

    idle(32'hDEAD_BEEF);
    idle(32'h0);
    idle(32'h0);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending results: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule